// File: doc/BRIEF.md
# Serial BCD to Excess-3 Converter

This block turns a stream of BCD digits that arrives one bit at a time into the matching stream of Excess-3 digits. Each digit is four bits long and arrives least significant bit first. Digits follow one another with no idle bits between them. For each accepted input bit the block produces, in the same cycle, the output bit of equal weight of the digit plus three. The output is a Mealy function of the current state and the present input bit.

Inside, a small state machine tracks two things: the bit position within the current digit and the carry of the running addition. The constant three is applied one bit per position. Any carry out of the top bit is dropped. After the fourth bit of a digit the machine starts the next digit afresh. A cycle with `in_valid` low is a pause, and the state does not change.

The states and transitions are:
- `ST_B0` is bit 0, with no carry. It goes to `ST_B1_C0` when the input is 0 and to `ST_B1_C1` when the input is 1.
- From `ST_B1_Cc`, a 0 input with c=0 goes to `ST_B2_C0`. Every other case goes to `ST_B2_C1`.
- From `ST_B2_Cc`, input 1 with c=1 goes to `ST_B3_C1`. Every other case goes to `ST_B3_C0`.
- Both `ST_B3_C0` and `ST_B3_C1` return to `ST_B0`.

Top module: `bcd_xs3_serial`

## Requirements
- R1: On a cycle with `in_valid` high, `out_bit` equals bit i of (D + 3) mod 16. Here D is the digit being received and i (0 to 3) is the position of the current bit, counted from the least significant bit. The output belongs to the same cycle as the input bit.
- R2: After every fourth accepted bit, the next accepted bit is bit 0 of a new digit. The carry out of bit 3 is discarded, so 13, 14 and 15 become 0, 1 and 2.
- R3: Input codes 10 to 15 are converted by the same rule, modulo 16, and nothing flags them.
- R4: A cycle with `in_valid` low changes no state, whatever the value on `in_bit`. The next accepted bit continues the same digit at the same position.
- R5: `rst_n` low asynchronously returns the machine to bit position 0 with carry 0. This holds even in the middle of a digit, so the first accepted bit after reset is bit 0 of a new digit.
- R6: At bit position 0, `out_bit` is the inverse of `in_bit`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | High when `in_bit` carries a data bit |
| in_bit | input | 1 | Serial BCD bit, least significant bit first |
| out_bit | output | 1 | Serial Excess-3 bit, same cycle as `in_bit` |

## Verification
The case hardest to reach from the ports is a carry that ripples all the way to the top bit and is then dropped, while pauses in `in_valid` fall in the middle of the same digit. To reach it, the stimulus sends every code from 0 to 15 back to back. It then repeats digits such as 5, 7 and 13 with idle cycles inserted after different bit positions, and toggles `in_bit` during those pauses. A reset in the middle of a digit, followed straight away by a full digit, shows that the position counter restarts.

// File: rtl/xs3_pkg.sv
package xs3_pkg;

    typedef enum logic [2:0] {
        ST_B0    = 3'd0,
        ST_B1_C0 = 3'd1,
        ST_B1_C1 = 3'd2,
        ST_B2_C0 = 3'd3,
        ST_B2_C1 = 3'd4,
        ST_B3_C0 = 3'd5,
        ST_B3_C1 = 3'd6
    } xs3_state_e;

    localparam int DIGIT_W = 4;
    localparam int POS_W   = $clog2(DIGIT_W);

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/xs3_next_state.sv
module xs3_next_state
    import xs3_pkg::*;
#(
    parameter logic [DIGIT_W-1:0] ADDEND = 4'b0011
) (
    input  xs3_state_e state,
    input  logic       in_valid,
    input  logic       in_bit,
    output xs3_state_e state_nxt
);

    logic cy;

    always_comb begin
        state_nxt = state;
        cy        = 1'b0;
        if (in_valid) begin
            unique case (state)
                ST_B0: begin
                    cy        = maj3(in_bit, ADDEND[0], 1'b0);
                    state_nxt = cy ? ST_B1_C1 : ST_B1_C0;
                end
                ST_B1_C0: begin
                    cy        = maj3(in_bit, ADDEND[1], 1'b0);
                    state_nxt = cy ? ST_B2_C1 : ST_B2_C0;
                end
                ST_B1_C1: begin
                    cy        = maj3(in_bit, ADDEND[1], 1'b1);
                    state_nxt = cy ? ST_B2_C1 : ST_B2_C0;
                end
                ST_B2_C0: begin
                    cy        = maj3(in_bit, ADDEND[2], 1'b0);
                    state_nxt = cy ? ST_B3_C1 : ST_B3_C0;
                end
                ST_B2_C1: begin
                    cy        = maj3(in_bit, ADDEND[2], 1'b1);
                    state_nxt = cy ? ST_B3_C1 : ST_B3_C0;
                end
                ST_B3_C0, ST_B3_C1: begin
                    state_nxt = ST_B0;
                end
                default: begin
                    state_nxt = ST_B0;
                end
            endcase
        end
    end

endmodule

// File: rtl/xs3_out_logic.sv
module xs3_out_logic
    import xs3_pkg::*;
#(
    parameter logic [DIGIT_W-1:0] ADDEND = 4'b0011
) (
    input  xs3_state_e state,
    input  logic       in_bit,
    output logic       out_bit
);

    logic k_bit;
    logic c_bit;

    always_comb begin
        unique case (state)
            ST_B0:    begin k_bit = ADDEND[0]; c_bit = 1'b0; end
            ST_B1_C0: begin k_bit = ADDEND[1]; c_bit = 1'b0; end
            ST_B1_C1: begin k_bit = ADDEND[1]; c_bit = 1'b1; end
            ST_B2_C0: begin k_bit = ADDEND[2]; c_bit = 1'b0; end
            ST_B2_C1: begin k_bit = ADDEND[2]; c_bit = 1'b1; end
            ST_B3_C0: begin k_bit = ADDEND[3]; c_bit = 1'b0; end
            ST_B3_C1: begin k_bit = ADDEND[3]; c_bit = 1'b1; end
            default:  begin k_bit = ADDEND[0]; c_bit = 1'b0; end
        endcase
        out_bit = in_bit ^ k_bit ^ c_bit;
    end

endmodule

// File: rtl/bcd_xs3_serial.sv
module bcd_xs3_serial
    import xs3_pkg::*;
#(
    parameter logic [DIGIT_W-1:0] ADDEND = 4'b0011
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic in_bit,
    output logic out_bit
);

    xs3_state_e state_q;
    xs3_state_e state_d;

    xs3_next_state #(.ADDEND(ADDEND)) i_next (
        .state     (state_q),
        .in_valid  (in_valid),
        .in_bit    (in_bit),
        .state_nxt (state_d)
    );

    xs3_out_logic #(.ADDEND(ADDEND)) i_out (
        .state   (state_q),
        .in_bit  (in_bit),
        .out_bit (out_bit)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_B0;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/xs3_chk.sv
module xs3_chk
    import xs3_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       in_bit,
    input logic       out_bit,
    input xs3_state_e state
);

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(state));

    // R2
    digit_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (state == ST_B3_C0 || state == ST_B3_C1)) |=> state == ST_B0);

    // R6
    b0_invert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_B0) |-> (out_bit == !in_bit));

    // R1
    b0_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && state == ST_B0 && in_bit) |=> state == ST_B1_C1);

    // R5
    always @(negedge clk) begin
        if (!rst_n) begin
            reset_pos_chk: assert (state == ST_B0);
        end
    end

endmodule

bind bcd_xs3_serial xs3_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_bit   (in_bit),
    .out_bit  (out_bit),
    .state    (state_q)
);

// File: tb/test_bcd_xs3_serial.sv
module test_bcd_xs3_serial;

    logic clk = 1'b0;
    logic rst_n = 1'b1;
    logic in_valid = 1'b0;
    logic in_bit = 1'b0;
    logic out_bit;

    int checks = 0;
    int failures = 0;
    bit exp_q[$];

    always #5 clk = ~clk;

    bcd_xs3_serial i_bcd_xs3_serial (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_bit   (in_bit),
        .out_bit  (out_bit)
    );

    task automatic check(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b time=%0t", req, act, exp, $time);
        end
    endtask

    function automatic void load_expected(input int d);
        int s = (d + 3) % 16;
        for (int i = 0; i < 4; i++) exp_q.push_back(s[i]);
    endfunction

    // gap_after: insert idle cycles after this bit index (-1 for none)
    task automatic send_digit(input int d, input int gap_after, input string force_req);
        string req;
        load_expected(d);
        for (int i = 0; i < 4; i++) begin
            @(posedge clk); #1;
            in_valid = 1'b1;
            in_bit   = d[i];
            @(negedge clk);
            if (force_req != "")      req = force_req;
            else if (i == 0)          req = "R6";
            else if (d > 9)           req = "R3";
            else if (i == 3)          req = "R2";
            else                      req = "R1";
            check(out_bit, exp_q.pop_front(), req);
            if (i == gap_after) begin
                @(posedge clk); #1;
                in_valid = 1'b0;
                for (int g = 0; g < 3; g++) begin
                    in_bit = ~in_bit;
                    @(posedge clk); #1;
                end
            end
        end
    endtask

    initial begin
        #1 rst_n = 1'b0;
        in_bit = 1'b1;
        @(negedge clk);
        check(out_bit, 1'b0, "R5");
        in_bit = 1'b0;
        #1 check(out_bit, 1'b1, "R5");
        @(posedge clk); #1 rst_n = 1'b1;

        for (int d = 0; d < 16; d++) send_digit(d, -1, "");
        send_digit(8, -1, "R2");
        send_digit(13, -1, "R2");
        send_digit(15, -1, "R2");

        send_digit(5, 0, "R4");
        send_digit(7, 1, "R4");
        send_digit(13, 2, "R4");
        send_digit(9, 3, "R4");
        send_digit(6, -1, "R4");

        // partial digit, then reset in the middle
        @(posedge clk); #1 in_valid = 1'b1; in_bit = 1'b1;
        @(posedge clk); #1 in_bit = 1'b1;
        @(posedge clk); #1 in_valid = 1'b0; rst_n = 1'b0;
        @(posedge clk); #1 rst_n = 1'b1;
        send_digit(4, -1, "R5");
        send_digit(7, -1, "R5");

        @(posedge clk); #1 in_valid = 1'b0;
        repeat (3) @(posedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #500000;
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule